// File: doc/BRIEF.md
# PLL Lock Wait Sequencer

This block supervises the wait for a phase-locked loop to report lock after it has been configured and released from reset. A one-cycle start request launches a run. The run is a series of attempts. Within each attempt the sequencer samples the lock indicator, then waits a fixed interval before it samples again, up to a fixed number of samples. When an attempt ends without lock, the next attempt begins. At the start of every attempt after the first, the block emits a one-cycle recovery request. Each later attempt owns its own request line, so the surrounding logic can apply a stronger corrective write each time. For example, the second attempt may set a single control bit and the third may load a fixed control word.

As soon as a sample finds lock high, the run ends with success and skips every remaining sample and attempt. If the last sample of the last attempt still finds lock low, the run ends with failure. The end of a run is marked by a one-cycle done pulse. The status flag then keeps its value until the next run is accepted.

The wait between samples is given in microseconds and converted to clock cycles from the clock frequency parameter. With the default values the block makes three attempts of up to 1000 samples each, 50 µs apart, on a 50 MHz clock.

Top module: `pll_lock_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, lock_ok and every recover_pulse bit are 0.
- R2: A start seen while the block is idle is accepted. From the next cycle busy is 1 and lock_ok is 0, and the first attempt begins without any recovery pulse.
- R3: A start seen while busy is 1 is ignored. The running sequence keeps its timing and its result.
- R4: When a sample finds lock_in high, the very next cycle carries done=1 with lock_ok=1, and no further samples or attempts follow. A lock seen on the first sample after start gives done in the third cycle after the start edge.
- R5: Within an attempt, consecutive samples of lock_in are CLK_KHZ*WAIT_US/1000 cycles apart plus one cycle. A lock_in pulse that falls wholly between two samples has no effect.
- R6: Each attempt takes at most POLLS samples, and the first sample comes one cycle after the attempt begins.
- R7: At most ATTEMPTS attempts are made. If every sample misses, done=1 with lock_ok=0 comes one cycle after the last sample.
- R8: At the start of attempt number k (1-based, k≥2), recover_pulse bit k-2 is 1 for exactly one cycle, one cycle before that attempt's first sample. At most one bit is set at a time, and no bit is set during the first attempt.
- R9: done is 1 for exactly one cycle, and busy is 0 in the cycle after it.
- R10: lock_ok keeps its value from the end of a run until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a lock wait |
| lock_in | input | 1 | Lock indicator from the PLL, already synchronised |
| busy | output | 1 | High from the accepted start through the done cycle |
| done | output | 1 | One-cycle end-of-run pulse |
| lock_ok | output | 1 | Result of the last run: 1 if lock was seen |
| recover_pulse | output | ATTEMPTS-1 | Bit k-2 pulses at the start of attempt k |

## Verification
The bench builds the block with CLK_KHZ=60 and WAIT_US=50, which gives a 3-cycle interval, with POLLS=4 and ATTEMPTS=3. A complete failing run is then 43 cycles long. At that size the bench can reach the exhausted-attempt failure, the recovery pulses for every later attempt, a success in the middle attempt, and a lock glitch placed inside a wait window, all while a cycle-accurate model checks every clock. The wait-cycle conversion with its default values is covered only by elaboration.

// File: rtl/lks_pkg.sv
package lks_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PREP  = 3'd1,
    ST_CHECK = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } lks_state_e;

  // Cycles of wait for a time in microseconds at a clock given in kHz.
  function automatic int unsigned wait_cycles(int unsigned clk_khz, int unsigned wait_us);
    int unsigned r;
    r = (clk_khz * wait_us) / 1000;
    if (r < 1) r = 1;
    return r;
  endfunction

  // Bits needed to hold indices 0 .. n-1.
  function automatic int unsigned cnt_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lks_interval_timer.sv
module lks_interval_timer #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int unsigned CW = lks_pkg::cnt_width(CYCLES);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= CW'(CYCLES - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

  // R5
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> run && (cnt == CW'(CYCLES - 1)));
endmodule

// File: rtl/lks_step_counter.sv
module lks_step_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic [lks_pkg::cnt_width(LIMIT)-1:0] idx,
  output logic at_last
);
  localparam int unsigned IW = lks_pkg::cnt_width(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (inc) idx <= idx + 1'b1;
  end

  assign at_last = (idx == IW'(LIMIT - 1));

  // R6 R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !at_last);
endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq #(
  parameter int unsigned CLK_KHZ  = 50000,
  parameter int unsigned WAIT_US  = 50,
  parameter int unsigned POLLS    = 1000,
  parameter int unsigned ATTEMPTS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                lock_in,
  output logic                busy,
  output logic                done,
  output logic                lock_ok,
  output logic [ATTEMPTS-2:0] recover_pulse
);
  import lks_pkg::*;

  localparam int unsigned POLL_CYCLES = wait_cycles(CLK_KHZ, WAIT_US);
  localparam int unsigned AW = cnt_width(ATTEMPTS);
  localparam int unsigned PW = cnt_width(POLLS);

  lks_state_e state, state_nx;

  logic [AW-1:0] att_idx;
  logic [PW-1:0] poll_idx;
  logic att_last, poll_last, wait_done;

  // Named internal events
  logic accept, sample_hit, sample_miss, attempt_over, give_up, next_attempt, wait_go;

  assign accept       = start && (state == ST_IDLE);
  assign sample_hit   = (state == ST_CHECK) && lock_in;
  assign sample_miss  = (state == ST_CHECK) && !lock_in;
  assign attempt_over = sample_miss && poll_last;
  assign give_up      = attempt_over && att_last;
  assign next_attempt = attempt_over && !att_last;
  assign wait_go      = sample_miss && !poll_last;

  lks_step_counter #(.LIMIT(ATTEMPTS)) u_att (
    .clk(clk), .rst_n(rst_n), .clr(accept), .inc(next_attempt),
    .idx(att_idx), .at_last(att_last)
  );

  lks_step_counter #(.LIMIT(POLLS)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(accept || next_attempt), .inc(wait_go),
    .idx(poll_idx), .at_last(poll_last)
  );

  lks_interval_timer #(.CYCLES(POLL_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(wait_go), .expired(wait_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (accept) state_nx = ST_PREP;
      ST_PREP:  state_nx = ST_CHECK;
      ST_CHECK: begin
        if (sample_hit || give_up) state_nx = ST_DONE;
        else if (next_attempt)     state_nx = ST_PREP;
        else                       state_nx = ST_WAIT;
      end
      ST_WAIT:  if (wait_done) state_nx = ST_CHECK;
      ST_DONE:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      lock_ok <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept)          lock_ok <= 1'b0;
      else if (sample_hit) lock_ok <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  for (genvar k = 0; k < ATTEMPTS - 1; k++) begin : g_recover
    assign recover_pulse[k] = (state == ST_PREP) && (att_idx == AW'(k + 1));
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !lock_ok && (recover_pulse == '0)));
  // R3
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);
  // R4
  lock_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hit |=> (done && lock_ok));
  // R5
  wait_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |-> (state == ST_WAIT));
  // R6
  poll_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_idx <= PW'(POLLS - 1));
  // R7
  give_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |=> (done && !lock_ok));
  // R8
  recover_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(recover_pulse));
  // R8
  recover_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recover_pulse != '0) |=> (recover_pulse == '0) && (state == ST_CHECK));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

// File: tb/pll_lock_seq_tb_top.sv
module pll_lock_seq_tb_top;
  localparam int unsigned CLK_KHZ  = 60;
  localparam int unsigned WAIT_US  = 50;
  localparam int unsigned POLLS    = 4;
  localparam int unsigned ATTEMPTS = 3;
  localparam int GAP = 3;                                    // 60 kHz * 50 us
  localparam int RUN_FAIL = ATTEMPTS * (1 + POLLS + (POLLS - 1) * GAP) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic lock_in = 1'b0;
  logic busy, done, lock_ok;
  logic [ATTEMPTS-2:0] recover_pulse;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pll_lock_seq #(.CLK_KHZ(CLK_KHZ), .WAIT_US(WAIT_US), .POLLS(POLLS), .ATTEMPTS(ATTEMPTS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .lock_in(lock_in),
    .busy(busy), .done(done), .lock_ok(lock_ok), .recover_pulse(recover_pulse)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 attempt start, 2 sampling, 3 waiting, 4 finished
  int  m_phase = 0, m_try = 0, m_misses = 0, m_left = 0;
  bit  m_ok = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_try = 0; m_misses = 0; m_left = 0; m_ok = 0;
    end else begin
      case (m_phase)
        0: if (start) begin m_phase = 1; m_try = 0; m_misses = 0; m_ok = 0; end
        1: m_phase = 2;
        2: if (lock_in) begin
             m_ok = 1; m_phase = 4;
           end else begin
             m_misses++;
             if (m_misses == POLLS) begin
               if (m_try == ATTEMPTS - 1) m_phase = 4;
               else begin m_try++; m_misses = 0; m_phase = 1; end
             end else begin
               m_left = GAP; m_phase = 3;
             end
           end
        3: begin m_left--; if (m_left == 0) m_phase = 2; end
        default: m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check("R2", int'(busy), int'(m_phase != 0), "busy vs model");
      check("R9", int'(done), int'(m_phase == 4), "done vs model");
      check("R10", int'(lock_ok), int'(m_ok), "lock_ok vs model");
      check("R8", int'(recover_pulse),
            (m_phase == 1 && m_try > 0) ? (1 << (m_try - 1)) : 0, "recover_pulse vs model");
    end
  end

  int took;
  bit got_ok;
  int seen0, seen1;

  task automatic run_seq(input bit lk, input int on_k, input int off_k, input int restart_k);
    int k;
    @(negedge clk); start = 1'b1; lock_in = lk;
    @(negedge clk); start = 1'b0;
    k = 1; seen0 = 0; seen1 = 0;
    while (!done && k < 500) begin
      if (recover_pulse[0]) seen0++;
      if (recover_pulse[1]) seen1++;
      start = (k == restart_k);
      if (k == on_k)  lock_in = 1'b1;
      if (k == off_k) lock_in = 1'b0;
      @(negedge clk);
      k++;
    end
    took = k;
    got_ok = lock_ok;
    start = 1'b0;
    lock_in = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'({busy, done, lock_ok}), 0, "outputs in reset");
    check("R1", int'(recover_pulse), 0, "recover_pulse in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'({busy, done, lock_ok}), 0, "outputs after reset");

    // R4 lock already present
    run_seq(1'b1, -1, -1, -1);
    check("R4", took, 3, "cycles to done, immediate lock");
    check("R4", int'(got_ok), 1, "status, immediate lock");
    @(negedge clk);
    check("R9", int'(busy), 0, "busy after done");

    // R10 status held while idle with lock toggling
    lock_in = 1'b0; repeat (4) @(negedge clk);
    check("R10", int'(lock_ok), 1, "status held while idle");

    // R7 R6 R8 all attempts exhausted
    run_seq(1'b0, -1, -1, -1);
    check("R7", took, RUN_FAIL, "cycles to failure");
    check("R7", int'(got_ok), 0, "status after exhaustion");
    check("R8", seen0, 1, "second-attempt pulse count");
    check("R8", seen1, 1, "third-attempt pulse count");

    // R3 restart while busy ignored
    run_seq(1'b0, -1, -1, 10);
    check("R3", took, RUN_FAIL, "cycles with ignored restart");
    check("R3", int'(got_ok), 0, "status with ignored restart");

    // R5 glitch between samples is ignored
    run_seq(1'b0, 3, 4, -1);
    check("R5", took, RUN_FAIL, "cycles with glitch in wait");
    check("R5", int'(got_ok), 0, "status with glitch in wait");

    // R5 lock rising during first wait seen at the second sample
    run_seq(1'b0, 3, -1, -1);
    check("R5", took, 3 + GAP + 1, "cycles to second-sample lock");
    check("R5", int'(got_ok), 1, "status at second sample");

    // R4 R8 lock at the first sample of the second attempt
    run_seq(1'b0, 16, -1, -1);
    check("R4", took, 17, "cycles to second-attempt lock");
    check("R4", int'(got_ok), 1, "status second-attempt lock");
    check("R8", seen0, 1, "second-attempt pulse before lock");
    check("R8", seen1, 0, "no third-attempt pulse");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule